// File: doc/BRIEF.md
# I2C Master Controller Register Bank

This block is the processor-facing register file of a byte-oriented I2C master. It sits on a 32-bit memory-mapped bus and holds eight 8-bit registers on word-aligned offsets: control, two status registers, clock control, extended clock control, two own-address registers and the data register. The bit-level engine and the SCL generator live outside. They send one-cycle event pulses and a few live bus-state levels into this block. In return they receive the control byte, the clock divider, the frequency-range selection, the own address and the transmit byte together with a load strobe.

Each event is held in a flag until a particular register access clears it. Depending on the event, the clearing access is a data write, a data read or a control write. The status registers are assembled from these flags and the live levels. The summary event bit and the level-sensitive interrupt are derived from the flags. A read returns the register byte in two byte lanes, and a write takes its byte from the lowest lane.

Top module: `i2cm_regbank`

## Requirements
- R1: After reset, every register reads 0x00 except own-address 2, which reads 0x40. The interrupt output is low.
- R2: The word index `addr_i[4:2]` selects the register: 0 control, 1 status 1, 2 status 2, 3 clock control, 4 own address 1, 5 own address 2, 6 data, 7 extended clock control. `addr_i[1:0]` is ignored. A write uses `wdata_i[7:0]` only. A read returns the byte in bits [7:0] and in bits [23:16], with all other bits zero.
- R3: Own-address 2 keeps only bits [7:5] (frequency range, `freq_sel_o`) and bits [2:1] (upper address bits), so writing 0xFF reads back 0xE6. Extended clock control keeps bits [4:0]. `clk_div_o` = {xclk[4:0], clk[6:0]}, `fast_o` = clock-control bit 7, and `own_addr_o` = {own2[2:1], own1}.
- R4: Writes to the two status registers have no effect.
- R5: Event pulse indices are 0 start sent, 1 byte done, 2 ten-bit header, 3 end of address, 4 ack failure, 5 stop seen, 6 arbitration lost, 7 bus error, 8 SCL fall, 9 DDC2B. Status 1 is {any, ten-bit, `tra_i`, `busy_i`, byte done, `adsl_i`, `msl_i`, start sent}, bit 7 first. Status 2 is {SCL fall, 0, end of address, ack failure, stop seen, arbitration lost, bus error, DDC2B}, bit 7 first. The "any" bit is set while any event flag is set.
- R6: A data write clears the start-sent and ten-bit-header flags.
- R7: The byte-done flag is cleared by a data write while `tra_i`=1 and by a data read while `tra_i`=0. A data access in the other direction leaves it set.
- R8: Any control write clears end of address and the other status 2 flags. Reading a status register clears nothing.
- R9: A control write with peripheral enable (bit 5) at 0 clears every event flag.
- R10: An event pulse in the same cycle as its clearing access leaves the flag set.
- R11: `irq_o` is high exactly while control bit 0 is 1 and the "any" bit is 1. It is a level, not a pulse.
- R12: A data write loads the data register and raises `tx_load_o` for the one following cycle, with `tx_byte_o` holding the byte. `rx_load_i` loads `rx_byte_i` into the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Register access in this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid while a read is selected |
| evt_pulse_i | input | 10 | One-cycle event pulses from the engine |
| tra_i | input | 1 | Live transmitter-mode level |
| busy_i | input | 1 | Live bus-busy level |
| adsl_i | input | 1 | Live addressed-as-slave level |
| msl_i | input | 1 | Live master-mode level |
| rx_load_i | input | 1 | Load a received byte into the data register |
| rx_byte_i | input | 8 | Received byte |
| irq_o | output | 1 | Level interrupt |
| ctrl_o | output | 8 | Control register to the engine |
| clk_div_o | output | 12 | SCL divider |
| fast_o | output | 1 | Fast-mode select |
| freq_sel_o | output | 3 | Input-clock range selection |
| own_addr_o | output | 10 | Own address |
| tx_byte_o | output | 8 | Data register contents |
| tx_load_o | output | 1 | Data register written by the processor |

## Verification
The hardest case to reach from the ports is a set pulse that lands in the same cycle as the access that clears it. The bench builds this with a combined task that drives the event input and the bus write in one cycle, and then reads the status back to confirm the flag survived. The direction-dependent clearing of the byte-done flag is the other tricky case. It is exercised by holding `tra_i` each way and issuing the data access that should not clear the flag before the one that should.

// File: rtl/i2cm_regbank_pkg.sv
package i2cm_regbank_pkg;
   localparam int REG_W   = 8;
   localparam int ADDR_W  = 5;
   localparam int NUM_REG = 8;
   localparam int NUM_EV  = 10;
   localparam int DIV_W   = 12;

   typedef enum logic [2:0] {
      RS_CTRL  = 3'd0,
      RS_STAT1 = 3'd1,
      RS_STAT2 = 3'd2,
      RS_CLK   = 3'd3,
      RS_OWN1  = 3'd4,
      RS_OWN2  = 3'd5,
      RS_DATA  = 3'd6,
      RS_XCLK  = 3'd7
   } reg_sel_e;

   localparam int EV_SB    = 0;
   localparam int EV_BTF   = 1;
   localparam int EV_ADD10 = 2;
   localparam int EV_ENDAD = 3;
   localparam int EV_AF    = 4;
   localparam int EV_STOPF = 5;
   localparam int EV_ARLO  = 6;
   localparam int EV_BERR  = 7;
   localparam int EV_SCLF  = 8;
   localparam int EV_DDC   = 9;

   localparam int CTRL_IE = 0;
   localparam int CTRL_PE = 5;
endpackage

// File: rtl/i2cm_cfgreg.sv
module i2cm_cfgreg #(
   parameter int          W    = 8,
   parameter logic [W-1:0] RST  = '0,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wd_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q_r;

   always_ff @(posedge clk) begin
      if (!rst_n)     q_r <= RST & MASK;
      else if (we_i)  q_r <= wd_i & MASK;
      else if (ld_i)  q_r <= ld_d_i & MASK;
   end

   assign q_o = q_r;
endmodule

// File: rtl/i2cm_evflags.sv
module i2cm_evflags #(
   parameter int N = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o,
   output logic         any_o
);
   logic [N-1:0] flag_r;

   for (genvar g = 0; g < N; g++) begin : g_flag
      // set dominates a clear arriving in the same cycle
      always_ff @(posedge clk) begin
         if (!rst_n) flag_r[g] <= 1'b0;
         else        flag_r[g] <= set_i[g] | (flag_r[g] & ~clr_i[g]);
      end
   end

   assign flag_o = flag_r;
   assign any_o  = |flag_r;
endmodule

// File: rtl/i2cm_rdmux.sv
module i2cm_rdmux #(
   parameter int DATA_W  = 32,
   parameter int REG_W   = 8,
   parameter int NUM_REG = 8,
   parameter bit DUP     = 1'b1,
   localparam int SEL_W  = $clog2(NUM_REG)
) (
   input  logic                     rd_i,
   input  logic [SEL_W-1:0]         sel_i,
   input  logic [NUM_REG*REG_W-1:0] regs_i,
   output logic [DATA_W-1:0]        rdata_o
);
   logic [REG_W-1:0] byte_w;

   assign byte_w = rd_i ? regs_i[sel_i*REG_W +: REG_W] : '0;

   if (DUP) begin : g_dup
      always_comb begin
         rdata_o                       = '0;
         rdata_o[REG_W-1:0]            = byte_w;
         rdata_o[2*REG_W +: REG_W]     = byte_w;
      end
   end else begin : g_single
      always_comb begin
         rdata_o            = '0;
         rdata_o[REG_W-1:0] = byte_w;
      end
   end
endmodule

// File: rtl/i2cm_regbank.sv
module i2cm_regbank
   import i2cm_regbank_pkg::*;
#(
   parameter int           DATA_W   = 32,
   parameter bit           RD_DUP   = 1'b1,
   parameter logic [7:0]   OWN2_RST = 8'h40
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel_i,
   input  logic                wr_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   rdata_o,
   input  logic [NUM_EV-1:0]   evt_pulse_i,
   input  logic                tra_i,
   input  logic                busy_i,
   input  logic                adsl_i,
   input  logic                msl_i,
   input  logic                rx_load_i,
   input  logic [REG_W-1:0]    rx_byte_i,
   output logic                irq_o,
   output logic [REG_W-1:0]    ctrl_o,
   output logic [DIV_W-1:0]    clk_div_o,
   output logic                fast_o,
   output logic [2:0]          freq_sel_o,
   output logic [REG_W+1:0]    own_addr_o,
   output logic [REG_W-1:0]    tx_byte_o,
   output logic                tx_load_o
);
   localparam logic [REG_W-1:0] OWN2_MASK = 8'hE6;
   localparam logic [REG_W-1:0] XCLK_MASK = 8'h1F;
   localparam int               SEL_W     = $clog2(NUM_REG);

   if (DATA_W < REG_W) begin : g_bad_width
      $error("DATA_W must hold one register byte");
   end
   if (RD_DUP && DATA_W < 3*REG_W) begin : g_bad_dup
      $error("lane duplication needs DATA_W of at least 24");
   end

   // access decode
   reg_sel_e         rsel;
   logic             acc_wr, acc_rd;
   logic [REG_W-1:0] wbyte;
   logic             unused_bits;

   assign rsel        = reg_sel_e'(addr_i[4:2]);
   assign acc_wr      = sel_i & wr_i;
   assign acc_rd      = sel_i & ~wr_i;
   assign wbyte       = wdata_i[REG_W-1:0];
   assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:REG_W]};

   logic cr_we, clk_we, own1_we, own2_we, dr_we, xclk_we, dr_rd, pe_off;
   assign cr_we   = acc_wr & (rsel == RS_CTRL);
   assign clk_we  = acc_wr & (rsel == RS_CLK);
   assign own1_we = acc_wr & (rsel == RS_OWN1);
   assign own2_we = acc_wr & (rsel == RS_OWN2);
   assign dr_we   = acc_wr & (rsel == RS_DATA);
   assign xclk_we = acc_wr & (rsel == RS_XCLK);
   assign dr_rd   = acc_rd & (rsel == RS_DATA);
   assign pe_off  = cr_we & ~wbyte[CTRL_PE];

   // writable registers
   logic [REG_W-1:0] cr_q, clk_q, own1_q, own2_q, dr_q, xclk_q;

   i2cm_cfgreg #(.W(REG_W), .RST('0), .MASK('1)) u_cr (
      .clk(clk), .rst_n(rst_n), .we_i(cr_we), .wd_i(wbyte),
      .ld_i(1'b0), .ld_d_i('0), .q_o(cr_q));
   i2cm_cfgreg #(.W(REG_W), .RST('0), .MASK('1)) u_clk (
      .clk(clk), .rst_n(rst_n), .we_i(clk_we), .wd_i(wbyte),
      .ld_i(1'b0), .ld_d_i('0), .q_o(clk_q));
   i2cm_cfgreg #(.W(REG_W), .RST('0), .MASK('1)) u_own1 (
      .clk(clk), .rst_n(rst_n), .we_i(own1_we), .wd_i(wbyte),
      .ld_i(1'b0), .ld_d_i('0), .q_o(own1_q));
   i2cm_cfgreg #(.W(REG_W), .RST(OWN2_RST), .MASK(OWN2_MASK)) u_own2 (
      .clk(clk), .rst_n(rst_n), .we_i(own2_we), .wd_i(wbyte),
      .ld_i(1'b0), .ld_d_i('0), .q_o(own2_q));
   i2cm_cfgreg #(.W(REG_W), .RST('0), .MASK(XCLK_MASK)) u_xclk (
      .clk(clk), .rst_n(rst_n), .we_i(xclk_we), .wd_i(wbyte),
      .ld_i(1'b0), .ld_d_i('0), .q_o(xclk_q));
   i2cm_cfgreg #(.W(REG_W), .RST('0), .MASK('1)) u_dr (
      .clk(clk), .rst_n(rst_n), .we_i(dr_we), .wd_i(wbyte),
      .ld_i(rx_load_i), .ld_d_i(rx_byte_i), .q_o(dr_q));

   // event clearing rules
   logic [NUM_EV-1:0] ev_clr, ev_flag;
   logic              ev_any;

   always_comb begin
      ev_clr            = {NUM_EV{cr_we}};
      ev_clr[EV_SB]     = dr_we | pe_off;
      ev_clr[EV_ADD10]  = dr_we | pe_off;
      ev_clr[EV_BTF]    = (dr_we & tra_i) | (dr_rd & ~tra_i) | pe_off;
   end

   i2cm_evflags #(.N(NUM_EV)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(evt_pulse_i), .clr_i(ev_clr),
      .flag_o(ev_flag), .any_o(ev_any));

   // status assembly
   logic [REG_W-1:0] sr1_w, sr2_w;
   assign sr1_w = {ev_any, ev_flag[EV_ADD10], tra_i, busy_i,
                   ev_flag[EV_BTF], adsl_i, msl_i, ev_flag[EV_SB]};
   assign sr2_w = {ev_flag[EV_SCLF], 1'b0, ev_flag[EV_ENDAD], ev_flag[EV_AF],
                   ev_flag[EV_STOPF], ev_flag[EV_ARLO], ev_flag[EV_BERR],
                   ev_flag[EV_DDC]};

   i2cm_rdmux #(.DATA_W(DATA_W), .REG_W(REG_W), .NUM_REG(NUM_REG), .DUP(RD_DUP)) u_rd (
      .rd_i(acc_rd),
      .sel_i(SEL_W'(rsel)),
      .regs_i({xclk_q, dr_q, own2_q, own1_q, clk_q, sr2_w, sr1_w, cr_q}),
      .rdata_o(rdata_o));

   // engine-side outputs
   logic tx_load_q;
   always_ff @(posedge clk) begin
      if (!rst_n) tx_load_q <= 1'b0;
      else        tx_load_q <= dr_we;
   end

   assign irq_o      = cr_q[CTRL_IE] & ev_any;
   assign ctrl_o     = cr_q;
   assign clk_div_o  = {xclk_q[4:0], clk_q[6:0]};
   assign fast_o     = clk_q[7];
   assign freq_sel_o = own2_q[7:5];
   assign own_addr_o = {own2_q[2:1], own1_q};
   assign tx_byte_o  = dr_q;
   assign tx_load_o  = tx_load_q;
endmodule

// File: rtl/i2cm_regbank_chk.sv
module i2cm_regbank_chk #(
   parameter int DATA_W = 32,
   parameter bit DUP    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_i,
   input logic              wr_i,
   input logic [4:0]        addr_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic [9:0]        evt_pulse_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              irq_o,
   input logic [7:0]        ctrl_o,
   input logic              tx_load_o
);
   logic rd_acc, wr_acc;
   assign rd_acc = sel_i && !wr_i;
   assign wr_acc = sel_i && wr_i;

   AST_SR2_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && addr_i[4:2] == 3'd2) |-> (rdata_o[6] == 1'b0)); // R5

   AST_OWN2_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && addr_i[4:2] == 3'd5) |-> (rdata_o[4:3] == 2'b00 && rdata_o[0] == 1'b0)); // R3

   AST_XCLK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && addr_i[4:2] == 3'd7) |-> (rdata_o[7:5] == 3'b000)); // R3

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_o[0] |-> !irq_o); // R11

   AST_TXLOAD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && addr_i[4:2] == 3'd6) |=> tx_load_o); // R12

   AST_TXLOAD_ONLY_WR: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load_o |-> $past(wr_acc && addr_i[4:2] == 3'd6)); // R12

   AST_DISABLE_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && addr_i[4:2] == 3'd0 && !wdata_i[5] && evt_pulse_i == 10'd0) |=> !irq_o); // R9

   if (DUP) begin : g_lane
      AST_LANE_DUP: assert property (@(posedge clk) disable iff (!rst_n)
         rd_acc |-> (rdata_o[23:16] == rdata_o[7:0] && rdata_o[15:8] == 8'h00
                     && rdata_o[DATA_W-1:24] == '0)); // R2
   end
endmodule

bind i2cm_regbank i2cm_regbank_chk #(.DATA_W(DATA_W), .DUP(RD_DUP)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
   .wdata_i(wdata_i), .evt_pulse_i(evt_pulse_i), .rdata_o(rdata_o),
   .irq_o(irq_o), .ctrl_o(ctrl_o), .tx_load_o(tx_load_o));

// File: tb/sim_i2cm_regbank.sv
module sim_i2cm_regbank;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, wr = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [9:0]  evt = '0;
   logic        tra = 1'b0, busy = 1'b0, adsl = 1'b0, msl = 1'b0;
   logic        rx_load = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        irq, fast, tx_load;
   logic [7:0]  ctrl, tx_byte;
   logic [11:0] clk_div;
   logic [2:0]  freq_sel;
   logic [9:0]  own_addr;

   int total = 0;
   int bad   = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_P/2) clk = ~clk;

   i2cm_regbank u0 (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .evt_pulse_i(evt), .tra_i(tra),
      .busy_i(busy), .adsl_i(adsl), .msl_i(msl), .rx_load_i(rx_load),
      .rx_byte_i(rx_byte), .irq_o(irq), .ctrl_o(ctrl), .clk_div_o(clk_div),
      .fast_o(fast), .freq_sel_o(freq_sel), .own_addr_o(own_addr),
      .tx_byte_o(tx_byte), .tx_load_o(tx_load));

   task automatic chk(input string t, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", t, act, expv);
      end
   endtask

   // monitor: compares read data against the scoreboard queue
   always @(negedge clk) begin
      if (sel && !wr && exp_q.size() > 0) begin
         chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
   end

   task automatic wr_raw(input logic [4:0] a, input logic [31:0] w);
      @(posedge clk); #1;
      sel = 1'b1; wr = 1'b1; addr = a; wdata = w;
      @(posedge clk); #1;
      sel = 1'b0; wr = 1'b0; wdata = '0;
   endtask

   task automatic wrb(input logic [4:0] a, input logic [7:0] b);
      wr_raw(a, {8'h00, b, 8'h00, b});
   endtask

   task automatic rd(input logic [4:0] a, input logic [7:0] b, input string t);
      @(posedge clk); #1;
      sel = 1'b1; wr = 1'b0; addr = a;
      exp_q.push_back({8'h00, b, 8'h00, b});
      tag_q.push_back(t);
      @(posedge clk); #1;
      sel = 1'b0;
   endtask

   task automatic pulse(input int idx);
      @(posedge clk); #1;
      evt = 10'd1 << idx;
      @(posedge clk); #1;
      evt = '0;
   endtask

   task automatic wr_with_pulse(input logic [4:0] a, input logic [7:0] b, input int idx);
      @(posedge clk); #1;
      sel = 1'b1; wr = 1'b1; addr = a; wdata = {8'h00, b, 8'h00, b};
      evt = 10'd1 << idx;
      @(posedge clk); #1;
      sel = 1'b0; wr = 1'b0; evt = '0;
   endtask

   initial begin
      #(CLK_P*20000);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(5'h00, 8'h00, "R1 ctrl");
      rd(5'h04, 8'h00, "R1 stat1");
      rd(5'h08, 8'h00, "R1 stat2");
      rd(5'h0C, 8'h00, "R1 clk");
      rd(5'h10, 8'h00, "R1 own1");
      rd(5'h14, 8'h40, "R1 own2");
      rd(5'h18, 8'h00, "R1 data");
      rd(5'h1C, 8'h00, "R1 xclk");
      @(negedge clk); chk("R1 irq", {31'd0, irq}, 32'd0);

      // R3 masks and derived outputs
      wrb(5'h0C, 8'hA5);  rd(5'h0C, 8'hA5, "R3 clk rw");
      wrb(5'h1C, 8'hFF);  rd(5'h1C, 8'h1F, "R3 xclk mask");
      wrb(5'h14, 8'hFF);  rd(5'h14, 8'hE6, "R3 own2 mask");
      wrb(5'h10, 8'h3C);
      @(negedge clk);
      chk("R3 clk_div", {20'd0, clk_div}, 32'h0000_0FA5);
      chk("R3 fast", {31'd0, fast}, 32'd1);
      chk("R3 own_addr", {22'd0, own_addr}, 32'h0000_033C);
      chk("R3 freq_sel", {29'd0, freq_sel}, 32'd7);

      // R2 low address bits ignored, only lane 0 written
      wrb(5'h0E, 8'h11);  rd(5'h0C, 8'h11, "R2 addr alias");
      wr_raw(5'h10, 32'hAA77_BB55); rd(5'h11, 8'h55, "R2 lane0 write");

      // R4 status writes ignored
      wrb(5'h04, 8'hFF); wrb(5'h08, 8'hFF);
      rd(5'h04, 8'h00, "R4 stat1 unchanged");
      rd(5'h08, 8'h00, "R4 stat2 unchanged");

      // R5 status layout
      tra = 1'b1; busy = 1'b1; msl = 1'b1;
      rd(5'h04, 8'h32, "R5 live levels");
      pulse(4);
      rd(5'h08, 8'h10, "R5 ack failure bit");
      rd(5'h04, 8'hB2, "R5 any bit");
      pulse(8); pulse(9);
      rd(5'h08, 8'h91, "R5 scl fall and ddc bits");

      // R8 status reads do not clear, control write does
      rd(5'h08, 8'h91, "R8 read keeps flags");
      wrb(5'h00, 8'h20);
      rd(5'h08, 8'h00, "R8 ctrl write clears stat2");
      pulse(3);
      rd(5'h08, 8'h20, "R8 end of address set");
      wrb(5'h00, 8'h20);
      rd(5'h08, 8'h00, "R8 end of address cleared");

      // R6 data write clears start and ten-bit flags
      pulse(0);
      rd(5'h04, 8'hB3, "R6 start set");
      wrb(5'h18, 8'h5A);
      @(negedge clk);
      chk("R12 tx_load high", {31'd0, tx_load}, 32'd1);
      chk("R12 tx_byte", {24'd0, tx_byte}, 32'h5A);
      @(negedge clk);
      chk("R12 tx_load one cycle", {31'd0, tx_load}, 32'd0);
      rd(5'h04, 8'h32, "R6 start cleared");
      pulse(2);
      rd(5'h04, 8'hF2, "R6 ten-bit set");
      wrb(5'h18, 8'h01);
      rd(5'h04, 8'h32, "R6 ten-bit cleared");

      // R7 byte-done clearing depends on direction
      pulse(1);
      rd(5'h18, 8'h01, "R7 data read while transmitting");
      rd(5'h04, 8'hBA, "R7 read keeps flag in transmit");
      wrb(5'h18, 8'h02);
      rd(5'h04, 8'h32, "R7 write clears in transmit");
      tra = 1'b0;
      pulse(1);
      wrb(5'h18, 8'h03);
      rd(5'h04, 8'h9A, "R7 write keeps flag in receive");
      rd(5'h18, 8'h03, "R7 data read in receive");
      rd(5'h04, 8'h12, "R7 read clears in receive");

      // R12 received byte load
      @(posedge clk); #1 rx_load = 1'b1; rx_byte = 8'hC3;
      @(posedge clk); #1 rx_load = 1'b0;
      rd(5'h18, 8'hC3, "R12 received byte");

      // R11 interrupt level
      wrb(5'h00, 8'h21);
      @(negedge clk); chk("R11 no event no irq", {31'd0, irq}, 32'd0);
      pulse(0);
      @(negedge clk); chk("R11 irq on event", {31'd0, irq}, 32'd1);
      wrb(5'h00, 8'h20);
      @(negedge clk); chk("R11 irq off by enable", {31'd0, irq}, 32'd0);
      rd(5'h04, 8'h93, "R11 flag still pending");
      wrb(5'h00, 8'h21);
      @(negedge clk); chk("R11 irq level again", {31'd0, irq}, 32'd1);
      wrb(5'h18, 8'h00);
      @(negedge clk); chk("R11 irq drops on clear", {31'd0, irq}, 32'd0);

      // R9 disable clears everything
      pulse(0); pulse(1); pulse(3); pulse(6);
      rd(5'h08, 8'h24, "R9 stat2 before disable");
      wrb(5'h00, 8'h00);
      rd(5'h04, 8'h12, "R9 stat1 cleared");
      rd(5'h08, 8'h00, "R9 stat2 cleared");

      // R10 set beats clear in the same cycle
      wr_with_pulse(5'h00, 8'h00, 4);
      rd(5'h08, 8'h10, "R10 ack failure survives ctrl write");
      wr_with_pulse(5'h18, 8'h44, 0);
      rd(5'h04, 8'h93, "R10 start survives data write");

      @(posedge clk);
      chk("scoreboard drained", exp_q.size(), 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule